// File: doc/BRIEF.md
# Fully Associative Tag Match and Recency Replacement Engine

This block holds the tags of a fully associative cache and resolves a lookup in one cycle. It compares the presented tag with every stored tag at once. It returns a hit flag and the binary index of the entry that holds the tag. The stored entries are split into equal sections. Each section encodes its own match into a short index and a section hit. A merge stage then turns the first section that hit into the full entry index.

Recency is kept as an age rank for each entry, and the ranks always form a permutation of 0 to ENTRIES-1. When the cache misses, the owner presents the missing tag on the fill port in a later cycle. The block writes that tag into the victim entry it reports on `victimIdx`. An empty entry is always taken before a used one. A single strobe empties every entry at once. With the default parameters there are 1024 entries of 26-bit tags, which suits 64-byte lines, since the tag is the address above the 6 offset bits.

Top module: `tagCamLru`

## Requirements
- R1: After reset, every entry is empty: `hit` is 0 for any lookup, `multiHit` is 0, and `victimIdx` is 0.
- R2: When `lookupValid` is 1 and a valid entry holds exactly `lookupTag`, `hit` is 1 in the same cycle and `hitIdx` gives that entry's index. Entry index = section number × (ENTRIES/SECTIONS) + position in the section.
- R3: An entry whose stored tag differs from `lookupTag` in any single bit does not match.
- R4: While `lookupValid` is 0, `hit`, `multiHit` and `hitIdx` are 0.
- R5: A fill writes `fillTag` into the entry shown on `victimIdx` in that cycle, and marks the entry valid. A lookup of that tag in the next cycle hits at that index.
- R6: While any entry is empty, `victimIdx` is the lowest-numbered empty entry.
- R7: Each entry has a rank, where 0 is the most recent. A lookup hit or a fill sets the accessed entry to rank 0 and adds one to every rank below the entry's old rank. When all entries are valid, `victimIdx` is the entry with rank ENTRIES-1.
- R8: If several valid entries match, `hit` is 1, `hitIdx` is the lowest matching index, and `multiHit` is 1. Only that lowest entry is touched for recency. In all other cases `multiHit` is 0.
- R9: `invalAll` empties every entry in one cycle and sets the rank of entry i to i.
- R10: `invalAll` takes priority over a fill, and a fill takes priority over a lookup hit for recency. A lookup presented during a fill or an invalidate still reports `hit` and `hitIdx`, but does not change any rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupTag | input | TAG_W | Tag to search for |
| fillEn | input | 1 | Write fillTag into the victim entry |
| fillTag | input | TAG_W | Tag to install |
| invalAll | input | 1 | Empty all entries and restore index-order ranks |
| hit | output | 1 | Lookup matched a valid entry (combinational) |
| hitIdx | output | IDX_W | Index of the lowest matching entry, 0 on a miss |
| multiHit | output | 1 | More than one entry matched |
| victimIdx | output | IDX_W | Entry the next fill will write |

## Verification
The assertions rely on the owner never filling a tag that is already stored. Only under that rule is `multiHit` a true error condition, and only then does the recency order match a single-copy cache. Random fills draw their tags from a counter multiplied by an odd constant modulo 2^26. This mapping never repeats a tag, so random traffic stays inside the rule. A single directed case then breaks the rule on purpose to exercise the duplicate-match handling. Lookups for a one-bit-flipped tag are checked against a reference model, so a flip that happens to equal another stored tag is still scored correctly.

// File: rtl/camPkg.sv
package camPkg;
  typedef struct packed {
    logic doInval;
    logic doFill;
    logic doTouch;
  } camStrobeT;
endpackage

// File: rtl/camCtrl.sv
module camCtrl
  import camPkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             lookupValid,
  input  logic             hit,
  input  logic             fillEn,
  input  logic             invalAll,
  input  logic             anyInvalid,
  input  logic [IDX_W-1:0] firstInvalIdx,
  input  logic [IDX_W-1:0] lruIdx,
  output camStrobeT        strobe,
  output logic [IDX_W-1:0] victimIdx
);
  // Empty entries are used up before any recency victim is taken.
  assign victimIdx = anyInvalid ? firstInvalIdx : lruIdx;

  // Priority: invalidate, then fill, then recency touch on a hit.
  always_comb begin
    strobe = '0;
    if (invalAll) begin
      strobe.doInval = 1'b1;
    end else if (fillEn) begin
      strobe.doFill = 1'b1;
    end else if (lookupValid && hit) begin
      strobe.doTouch = 1'b1;
    end
  end
endmodule

// File: rtl/camData.sv
module camData
  import camPkg::*;
#(
  parameter int TAG_W    = 26,
  parameter int ENTRIES  = 1024,
  parameter int SECTIONS = 8,
  parameter int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic [TAG_W-1:0] fillTag,
  input  camStrobeT        strobe,
  input  logic [IDX_W-1:0] victimIdx,
  output logic             hit,
  output logic [IDX_W-1:0] hitIdx,
  output logic             multiHit,
  output logic             anyInvalid,
  output logic [IDX_W-1:0] firstInvalIdx,
  output logic [IDX_W-1:0] lruIdx
);
  localparam int SECT_SZ = ENTRIES / SECTIONS;
  localparam int SECT_W  = $clog2(SECT_SZ);
  localparam int SEL_W   = $clog2(SECTIONS);

  logic [TAG_W-1:0]         tagQ  [ENTRIES];
  logic [IDX_W-1:0]         rankQ [ENTRIES];
  logic [ENTRIES-1:0]       validQ;
  logic [ENTRIES-1:0]       matchVec;
  logic [SECTIONS-1:0]      sectHit;
  logic [SECTIONS-1:0]      sectMulti;
  logic [SECTIONS*SECT_W-1:0] sectIdxFlat;
  logic [SEL_W-1:0]         hitSect;
  logic [IDX_W-1:0]         touchIdx;
  logic [IDX_W-1:0]         oldRank;
  logic                     doUpdate;

  // Parallel compare of every stored tag.
  for (genvar e = 0; e < ENTRIES; e++) begin : gMatch
    assign matchVec[e] = lookupValid && validQ[e] && (tagQ[e] == lookupTag);
  end

  // Per-section encode: lowest matching position, section hit, section multi.
  for (genvar s = 0; s < SECTIONS; s++) begin : gSect
    logic [SECT_SZ-1:0] slice;
    logic [SECT_W-1:0]  localIdx;
    assign slice = matchVec[s*SECT_SZ +: SECT_SZ];
    always_comb begin
      localIdx = '0;
      for (int k = SECT_SZ - 1; k >= 0; k--) begin
        if (slice[k]) localIdx = SECT_W'(k);
      end
    end
    assign sectHit[s]   = |slice;
    assign sectMulti[s] = |(slice & (slice - 1'b1));
    assign sectIdxFlat[s*SECT_W +: SECT_W] = localIdx;
  end

  // Merge section results: lowest section with a hit wins.
  always_comb begin
    hitSect = '0;
    for (int s = SECTIONS - 1; s >= 0; s--) begin
      if (sectHit[s]) hitSect = SEL_W'(s);
    end
  end

  assign hit      = |sectHit;
  assign hitIdx   = hit ? {hitSect, sectIdxFlat[hitSect*SECT_W +: SECT_W]} : '0;
  assign multiHit = (|sectMulti) || (|(sectHit & (sectHit - 1'b1)));

  // Victim candidates.
  always_comb begin
    firstInvalIdx = '0;
    lruIdx        = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!validQ[e]) firstInvalIdx = IDX_W'(e);
      if (rankQ[e] == IDX_W'(ENTRIES - 1)) lruIdx = IDX_W'(e);
    end
  end
  assign anyInvalid = ~&validQ;

  // Recency and valid state.
  assign doUpdate = strobe.doFill || strobe.doTouch;
  assign touchIdx = strobe.doFill ? victimIdx : hitIdx;
  assign oldRank  = rankQ[touchIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int e = 0; e < ENTRIES; e++) rankQ[e] <= IDX_W'(e);
    end else if (strobe.doInval) begin
      validQ <= '0;
      for (int e = 0; e < ENTRIES; e++) rankQ[e] <= IDX_W'(e);
    end else if (doUpdate) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (IDX_W'(e) == touchIdx) rankQ[e] <= '0;
        else if (rankQ[e] < oldRank) rankQ[e] <= rankQ[e] + 1'b1;
      end
      if (strobe.doFill) validQ[victimIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doFill) tagQ[victimIdx] <= fillTag;
  end

  // Assertions
  p_idle_no_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> (!hit && !multiHit));

  p_multi_implies_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    multiHit |-> hit);

  p_fill_installs_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doFill |=> (validQ[$past(victimIdx)] && tagQ[$past(victimIdx)] == $past(fillTag)));

  p_touch_mru_r7: assert property (@(posedge clk) disable iff (!rstN)
    doUpdate |=> (rankQ[$past(touchIdx)] == '0));

  p_inval_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doInval |=> (validQ == '0 && rankQ[ENTRIES-1] == IDX_W'(ENTRIES - 1)));

  p_no_empty_victim_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyInvalid |-> !validQ[firstInvalIdx]);
endmodule

// File: rtl/tagCamLru.sv
module tagCamLru
  import camPkg::*;
#(
  parameter int TAG_W    = 26,
  parameter int ENTRIES  = 1024,
  parameter int SECTIONS = 8,
  parameter int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic             fillEn,
  input  logic [TAG_W-1:0] fillTag,
  input  logic             invalAll,
  output logic             hit,
  output logic [IDX_W-1:0] hitIdx,
  output logic             multiHit,
  output logic [IDX_W-1:0] victimIdx
);
  camStrobeT        strobe;
  logic             anyInvalid;
  logic [IDX_W-1:0] firstInvalIdx;
  logic [IDX_W-1:0] lruIdx;

  camCtrl #(.IDX_W(IDX_W)) uCtrl (
    .lookupValid  (lookupValid),
    .hit          (hit),
    .fillEn       (fillEn),
    .invalAll     (invalAll),
    .anyInvalid   (anyInvalid),
    .firstInvalIdx(firstInvalIdx),
    .lruIdx       (lruIdx),
    .strobe       (strobe),
    .victimIdx    (victimIdx)
  );

  camData #(.TAG_W(TAG_W), .ENTRIES(ENTRIES), .SECTIONS(SECTIONS), .IDX_W(IDX_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .lookupValid  (lookupValid),
    .lookupTag    (lookupTag),
    .fillTag      (fillTag),
    .strobe       (strobe),
    .victimIdx    (victimIdx),
    .hit          (hit),
    .hitIdx       (hitIdx),
    .multiHit     (multiHit),
    .anyInvalid   (anyInvalid),
    .firstInvalIdx(firstInvalIdx),
    .lruIdx       (lruIdx)
  );
endmodule

// File: tb/sim_tagCamLru.sv
module sim_tagCamLru;
  localparam int TW = 26;
  localparam int N  = 1024;
  localparam int IW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupValid = 1'b0;
  logic [TW-1:0] lookupTag = '0;
  logic          fillEn = 1'b0;
  logic [TW-1:0] fillTag = '0;
  logic          invalAll = 1'b0;
  logic          hit;
  logic [IW-1:0] hitIdx;
  logic          multiHit;
  logic [IW-1:0] victimIdx;

  tagCamLru u0 (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupTag(lookupTag),
    .fillEn(fillEn), .fillTag(fillTag), .invalAll(invalAll),
    .hit(hit), .hitIdx(hitIdx), .multiHit(multiHit), .victimIdx(victimIdx)
  );

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int serial = 0;
  bit done = 0;

  logic [TW-1:0] mTag [N];
  bit            mValid [N];
  int            mRank [N];

  bit eHit, eMulti;
  int eIdx, eVict;

  task automatic checkEq(input int act, input int exp, input string req, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] newTag();
    serial++;
    return TW'(serial * 32'h01B3D5F7);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0;
      mRank[i] = i;
    end
  endtask

  task automatic modelEval(input bit lv, input logic [TW-1:0] lt);
    int cnt = 0;
    eHit = 0; eIdx = 0; eMulti = 0;
    if (lv) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (mValid[i] && mTag[i] == lt) begin
          eIdx = i;
          cnt++;
        end
      end
    end
    eHit = (cnt > 0);
    eMulti = (cnt > 1);
    eVict = -1;
    for (int i = N - 1; i >= 0; i--) if (!mValid[i]) eVict = i;
    if (eVict < 0) begin
      for (int i = 0; i < N; i++) if (mRank[i] == N - 1) eVict = i;
    end
  endtask

  task automatic modelTouch(input int k);
    int old = mRank[k];
    for (int i = 0; i < N; i++) begin
      if (i == k) mRank[i] = 0;
      else if (mRank[i] < old) mRank[i]++;
    end
  endtask

  task automatic step(input bit lv, input logic [TW-1:0] lt, input bit fe,
                      input logic [TW-1:0] ft, input bit ia, input string req);
    @(negedge clk);
    lookupValid = lv; lookupTag = lt; fillEn = fe; fillTag = ft; invalAll = ia;
    #1;
    modelEval(lv, lt);
    checkEq(int'(hit), int'(eHit), req, "hit");
    checkEq(int'(hitIdx), eHit ? eIdx : 0, req, "hitIdx");
    checkEq(int'(multiHit), int'(eMulti), req, "multiHit");
    checkEq(int'(victimIdx), eVict, req, "victimIdx");
    if (ia) modelReset();
    else if (fe) begin
      mTag[eVict] = ft;
      mValid[eVict] = 1;
      modelTouch(eVict);
    end else if (eHit) modelTouch(eIdx);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected below 200000", cyc);
        finishRun();
      end
    end
  end

  initial begin
    logic [TW-1:0] t;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: empty after reset
    step(1, 26'h0000123, 0, '0, 0, "R1");
    step(1, 26'h0000000, 0, '0, 0, "R1");

    // R6 victim order while filling; R5 lookup right after each fill
    for (int i = 0; i < N; i++) begin
      t = newTag();
      step(0, '0, 1, t, 0, "R6");
      step(1, t, 0, '0, 0, "R5");
    end

    // R2 exact match, R3 single-bit differences, R4 idle lookup
    step(1, mTag[5], 0, '0, 0, "R2");
    for (int k = 0; k < TW; k++) step(1, mTag[5] ^ (TW'(1) << k), 0, '0, 0, "R3");
    step(0, mTag[9], 0, '0, 0, "R4");
    step(1, mTag[N-1], 0, '0, 0, "R2");

    // R10: lookup alongside fill and alongside invalidate-free fill priority
    step(1, mTag[7], 1, newTag(), 0, "R10");
    step(1, mTag[8], 0, '0, 0, "R10");

    // Random traffic: R2, R3, R4, R7
    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom_range(0, 9));
      int j  = int'($urandom_range(0, N - 1));
      if (op < 5) step(1, mTag[j], 0, '0, 0, "R2");
      else if (op < 6) step(1, mTag[j] ^ (TW'(1) << $urandom_range(0, TW - 1)), 0, '0, 0, "R3");
      else if (op < 7) step(0, mTag[j], 0, '0, 0, "R4");
      else if (op < 9) step(0, '0, 1, newTag(), 0, "R7");
      else step(1, mTag[j], 1, newTag(), 0, "R10");
    end

    // R7 directed: touch the current victim, victim must move
    step(1, mTag[eVict], 0, '0, 0, "R7");
    step(0, '0, 0, '0, 0, "R7");

    // R8: deliberate duplicate tag
    t = newTag();
    step(0, '0, 1, t, 0, "R8");
    step(0, '0, 1, t, 0, "R8");
    step(1, t, 0, '0, 0, "R8");
    checkEq(int'(multiHit), 1, "R8", "duplicate flagged");
    step(1, t, 0, '0, 0, "R8");

    // R10: invalidate beats fill; R9: everything empty afterwards
    step(1, t, 1, newTag(), 1, "R10");
    step(1, t, 0, '0, 0, "R9");
    checkEq(int'(hit), 0, "R9", "hit after invalidate");
    step(1, mTag[3], 0, '0, 0, "R9");
    for (int i = 0; i < 40; i++) step(0, '0, 1, newTag(), 0, "R9");
    for (int i = 0; i < 40; i++) step(1, mTag[i], 0, '0, 0, "R9");

    done = 1;
    finishRun();
  end
endmodule